// File: doc/BRIEF.md
# Two-Port Interrupt Status Aggregator

This block gathers interrupt events from a set of storage ports, by default two, into one level-sensitive interrupt line for the host. Each port has six event inputs: device removed, device attached, command finished, fatal fault, device-raised interrupt and reply queue holding entries. A one-cycle pulse on an event input sets a sticky status bit. Software clears that bit by writing a one to it. A per-port mask byte decides which of the latched events count toward that port's pending summary.

At host level the per-port pending summaries form the low bits of a host status word. A software-raised interrupt bit and a global summary bit sit beside them. A host mask selects which of these sources reach the global summary. An interrupt-off bit in a host control register holds the output low whatever the status is. Software reaches every register through a simple register port: one write strobe, and a read value that follows the address combinationally with no side effects on read.

Top module: `irqagg_top`

## Requirements
- R1: After reset, every port status reads 0x00 and every port mask reads 0xFF. Host status reads 0x0000, the host mask reads 0x4003 (port bits and bit 14 set), host control reads 0x0100 and `irq_o` is low.
- R2: A high level on an event input during a clock edge sets the matching port status bit after that edge, and the bit stays set. The bit positions are 0 removed, 1 attached, 2 command finished, 3 fatal fault, 4 device interrupt and 5 reply queue. The mask does not affect this latching.
- R3: A write to a port status register clears exactly the bits written as one and leaves the others, so writing back a value just read clears only the events seen in it.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit is set after that edge.
- R5: Port status bit 7 is read-only. It reads 1 exactly when some status bit is set whose mask bit is 0. Bit 6 reads 0. Writes to bits 6 and 7 have no effect.
- R6: A port mask bit at 1 keeps that event out of the port's pending summary. A mask of 0xFF silences the port. A mask of 0x30 lets through removed, attached, command finished and fatal fault, and blocks device interrupt and reply queue.
- R7: Host status bit p (p = 0 or 1) mirrors port p's pending summary and is read-only, as is bit 15.
- R8: Host mask bits 0, 1 and 14 block the matching host status source when 1. Host status bit 15 reads 1 exactly when some host source is set with its host mask bit 0.
- R9: Host status bit 14 is a software interrupt that takes the value written to bit 14 of host status.
- R10: `irq_o` is high exactly when host status bit 15 is 1 and host control bit 8 is 0. It stays high, level-sensitive, until a register write removes the cause.
- R11: The register map is: port p status at p*0x40+0x09, port p mask at p*0x40+0x0A, host control at 0x7C, host status at 0xBC and host mask at 0xBE. Host control keeps only bit 8. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_evt_i | input | NUM_PORTS*6 | Event pulses, six per port, port p at bits [6p+5:6p] |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_we_i | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata_i | input | 16 | Write data; port registers use bits [7:0] |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level-sensitive interrupt line |

## Verification
The aggregation path is driven with one masked event on one port, and with all six events on the other port under a full mask and then an open mask. Comparing these cases shows that latching does not depend on the mask while the summaries do. A clearing write that lands in the same cycle as a fresh event on the same bit shows whether the event takes priority. Writing back a mix of set and clear bits shows that clearing is exact. Each gate in turn (port mask, host mask, interrupt-off) is opened and closed on its own while a cause is held, and the software bit is used as a source with no port activity. This ties each change of `irq_o` to exactly one control.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   localparam int EVT_W     = 6;   // events per port
   localparam int BYTE_W    = 8;
   localparam int HOST_W    = 16;
   localparam int PEND_BIT  = 7;   // read-only port pending summary
   localparam int SWI_BIT   = 14;  // software interrupt in host status
   localparam int SUM_BIT   = 15;  // global summary in host status
   localparam int OFF_BIT   = 8;   // interrupt-off in host control

   typedef enum int unsigned {
      EV_GONE   = 0,
      EV_ARRIVE = 1,
      EV_DONE   = 2,
      EV_FATAL  = 3,
      EV_DEV    = 4,
      EV_REPLY  = 5
   } evt_pos_e;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_PSTAT,
      RK_PMASK,
      RK_HSTAT,
      RK_HMASK,
      RK_HCTL
   } reg_kind_e;

   localparam logic [BYTE_W-1:0] PMASK_RESET = 8'hFF;
   localparam logic [HOST_W-1:0] HCTL_RESET  = 16'h0100;
endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode
   import irqagg_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int NUM_PORTS   = 2,
   parameter int STRIDE_LOG2 = 6,
   parameter int PSTAT_OFF   = 'h09,
   parameter int PMASK_OFF   = 'h0A,
   parameter int HCTL_ADDR   = 'h7C,
   parameter int HSTAT_ADDR  = 'hBC,
   parameter int HMASK_ADDR  = 'hBE,
   localparam int PIDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_kind_e         kind_o,
   output logic [PIDX_W-1:0] pidx_o
);
   localparam int SEL_W = ADDR_W - STRIDE_LOG2;

   logic [SEL_W-1:0]       sel;
   logic [STRIDE_LOG2-1:0] off;

   assign sel    = addr_i[ADDR_W-1:STRIDE_LOG2];
   assign off    = addr_i[STRIDE_LOG2-1:0];
   assign pidx_o = PIDX_W'(sel);

   always_comb begin
      kind_o = RK_NONE;
      if (addr_i == ADDR_W'(HCTL_ADDR))
         kind_o = RK_HCTL;
      else if (addr_i == ADDR_W'(HSTAT_ADDR))
         kind_o = RK_HSTAT;
      else if (addr_i == ADDR_W'(HMASK_ADDR))
         kind_o = RK_HMASK;
      else if (32'(sel) < NUM_PORTS) begin
         if (off == STRIDE_LOG2'(PSTAT_OFF))
            kind_o = RK_PSTAT;
         else if (off == STRIDE_LOG2'(PMASK_OFF))
            kind_o = RK_PMASK;
      end
   end
endmodule

// File: rtl/irqagg_port.sv
module irqagg_port
   import irqagg_pkg::*;
#(
   parameter int               NEV      = EVT_W,
   parameter logic [BYTE_W-1:0] MASK_RST = PMASK_RESET
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NEV-1:0]    evt_i,
   input  logic              stat_we_i,
   input  logic              mask_we_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [NEV-1:0]    stat_o,
   output logic [BYTE_W-1:0] mask_o,
   output logic              pend_o,
   output logic [BYTE_W-1:0] stat_rd_o
);
   if (NEV > PEND_BIT) begin : g_bad_nev
      $error("irqagg_port: event count overlaps the pending bit");
   end

   logic [NEV-1:0]    stat_q;
   logic [BYTE_W-1:0] mask_q;

   // One sticky flop per event; a new event outranks a same-cycle clear.
   for (genvar b = 0; b < NEV; b++) begin : g_bit
      logic clr;
      assign clr = stat_we_i & wdata_i[b];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stat_q[b] <= 1'b0;
         else
            stat_q[b] <= evt_i[b] | (stat_q[b] & ~clr);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= MASK_RST;
      else if (mask_we_i)
         mask_q <= wdata_i;
   end

   assign pend_o = |(stat_q & ~mask_q[NEV-1:0]);
   assign stat_o = stat_q;
   assign mask_o = mask_q;

   always_comb begin
      stat_rd_o           = '0;
      stat_rd_o[NEV-1:0]  = stat_q;
      stat_rd_o[PEND_BIT] = pend_o;
   end
endmodule

// File: rtl/irqagg_host.sv
module irqagg_host
   import irqagg_pkg::*;
#(
   parameter int NUM_PORTS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] pend_i,
   input  logic                 hstat_we_i,
   input  logic                 hmask_we_i,
   input  logic                 hctl_we_i,
   input  logic [HOST_W-1:0]    wdata_i,
   output logic [HOST_W-1:0]    hstat_o,
   output logic [HOST_W-1:0]    hmask_o,
   output logic [HOST_W-1:0]    hctl_o,
   output logic                 swi_o,
   output logic                 off_o,
   output logic                 irq_o
);
   // Bits of the host mask that exist: one per port plus the software bit.
   localparam logic [HOST_W-1:0] HMASK_BITS =
      HOST_W'((1 << NUM_PORTS) - 1) | (HOST_W'(1) << SWI_BIT);

   logic [HOST_W-1:0] hmask_q;
   logic              swi_q;
   logic              off_q;
   logic              summary;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hmask_q <= HMASK_BITS;
         swi_q   <= 1'b0;
         off_q   <= HCTL_RESET[OFF_BIT];
      end else begin
         if (hmask_we_i) hmask_q <= wdata_i & HMASK_BITS;
         if (hstat_we_i) swi_q   <= wdata_i[SWI_BIT];
         if (hctl_we_i)  off_q   <= wdata_i[OFF_BIT];
      end
   end

   assign summary = (|(pend_i & ~hmask_q[NUM_PORTS-1:0])) |
                    (swi_q & ~hmask_q[SWI_BIT]);

   always_comb begin
      hstat_o                  = '0;
      hstat_o[NUM_PORTS-1:0]   = pend_i;
      hstat_o[SWI_BIT]         = swi_q;
      hstat_o[SUM_BIT]         = summary;
      hctl_o                   = '0;
      hctl_o[OFF_BIT]          = off_q;
   end

   assign hmask_o = hmask_q;
   assign swi_o   = swi_q;
   assign off_o   = off_q;
   assign irq_o   = summary & ~off_q;
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
   import irqagg_pkg::*;
#(
   parameter int NUM_PORTS   = 2,
   parameter int ADDR_W      = 8,
   parameter int STRIDE_LOG2 = 6,
   localparam int EV_TOT     = NUM_PORTS * EVT_W,
   localparam int PIDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EV_TOT-1:0] port_evt_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_we_i,
   input  logic [HOST_W-1:0] reg_wdata_i,
   output logic [HOST_W-1:0] reg_rdata_o,
   output logic              irq_o
);
   if (NUM_PORTS < 1 || NUM_PORTS > SWI_BIT) begin : g_bad_ports
      $error("irqagg_top: NUM_PORTS must be 1..14");
   end
   if ((NUM_PORTS << STRIDE_LOG2) > (1 << ADDR_W)) begin : g_bad_span
      $error("irqagg_top: port blocks exceed the address space");
   end

   reg_kind_e         kind;
   logic [PIDX_W-1:0] pidx;

   logic [EV_TOT-1:0]           st_flat;
   logic [NUM_PORTS*BYTE_W-1:0] mk_flat;
   logic [NUM_PORTS-1:0]        pend_v;
   logic [BYTE_W-1:0]           stat_rd_a [NUM_PORTS];
   logic [HOST_W-1:0]           hstat, hmask, hctl;
   logic                        swi_q, irq_off_q;

   irqagg_decode #(
      .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .STRIDE_LOG2(STRIDE_LOG2)
   ) u_dec (
      .addr_i(reg_addr_i), .kind_o(kind), .pidx_o(pidx)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic hit;
      assign hit = (32'(pidx) == p);
      irqagg_port #(.NEV(EVT_W)) u_port (
         .clk       (clk),
         .rst_n     (rst_n),
         .evt_i     (port_evt_i[p*EVT_W +: EVT_W]),
         .stat_we_i (reg_we_i & hit & (kind == RK_PSTAT)),
         .mask_we_i (reg_we_i & hit & (kind == RK_PMASK)),
         .wdata_i   (reg_wdata_i[BYTE_W-1:0]),
         .stat_o    (st_flat[p*EVT_W +: EVT_W]),
         .mask_o    (mk_flat[p*BYTE_W +: BYTE_W]),
         .pend_o    (pend_v[p]),
         .stat_rd_o (stat_rd_a[p])
      );
   end

   irqagg_host #(.NUM_PORTS(NUM_PORTS)) u_host (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend_i     (pend_v),
      .hstat_we_i (reg_we_i & (kind == RK_HSTAT)),
      .hmask_we_i (reg_we_i & (kind == RK_HMASK)),
      .hctl_we_i  (reg_we_i & (kind == RK_HCTL)),
      .wdata_i    (reg_wdata_i),
      .hstat_o    (hstat),
      .hmask_o    (hmask),
      .hctl_o     (hctl),
      .swi_o      (swi_q),
      .off_o      (irq_off_q),
      .irq_o      (irq_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      unique case (kind)
         RK_PSTAT: reg_rdata_o[BYTE_W-1:0] = stat_rd_a[pidx];
         RK_PMASK: reg_rdata_o[BYTE_W-1:0] = mk_flat[32'(pidx)*BYTE_W +: BYTE_W];
         RK_HSTAT: reg_rdata_o = hstat;
         RK_HMASK: reg_rdata_o = hmask;
         RK_HCTL:  reg_rdata_o = hctl;
         default:  reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
   import irqagg_pkg::*;
#(
   parameter int NUM_PORTS = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        reg_we,
   input logic [NUM_PORTS*EVT_W-1:0]  evt,
   input logic [NUM_PORTS*EVT_W-1:0]  st,
   input logic [NUM_PORTS*BYTE_W-1:0] mk,
   input logic [NUM_PORTS-1:0]        pend,
   input logic                        swi,
   input logic                        irq_off,
   input logic                        irq
);
   for (genvar k = 0; k < NUM_PORTS*EVT_W; k++) begin : g_ev
      p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
         evt[k] |=> st[k]);
      p_evt_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[k] && reg_we) |=> st[k]);
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pm
      p_full_mask_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (mk[p*BYTE_W +: BYTE_W] == 8'hFF) |-> !pend[p]);
   end

   p_status_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we && evt == '0) |=> $stable(st));

   p_quiet_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0 && !swi) |-> !irq);

   p_off_forces_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_off |-> !irq);

   p_level_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !reg_we) |=> irq);
endmodule

bind irqagg_top irqagg_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_we  (reg_we_i),
   .evt     (port_evt_i),
   .st      (st_flat),
   .mk      (mk_flat),
   .pend    (pend_v),
   .swi     (swi_q),
   .irq_off (irq_off_q),
   .irq     (irq_o)
);

// File: tb/tb_irqagg_top.sv
module tb_irqagg_top;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 2;
   localparam int EW = 6;

   localparam logic [7:0] P0S = 8'h09, P0M = 8'h0A, P1S = 8'h49, P1M = 8'h4A;
   localparam logic [7:0] HC = 8'h7C, HS = 8'hBC, HM = 8'hBE;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NP*EW-1:0] evt = '0;
   logic [7:0]     addr = '0;
   logic           we = 1'b0;
   logic [15:0]    wdata = '0;
   logic [15:0]    rdata;
   logic           irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [15:0] exp;
      string       req;
   } item_t;

   item_t sb_q[$];
   event  smp_ev;

   always #(CLK_PERIOD/2) clk = ~clk;

   irqagg_top #(.NUM_PORTS(NP)) dut (
      .clk(clk), .rst_n(rst_n), .port_evt_i(evt),
      .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq)
   );

   // Monitor: pops one expected item per sample and compares.
   initial begin
      forever begin
         @(smp_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {15'b0, irq} : rdata;
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
            end
         end
      end
   end

   task automatic rd(input logic [7:0] a, input logic [15:0] e, input string r);
      @(negedge clk);
      addr = a;
      #1;
      sb_q.push_back('{1'b0, e, r});
      ->smp_ev;
   endtask

   task automatic irq_chk(input logic e, input string r);
      @(negedge clk);
      #1;
      sb_q.push_back('{1'b1, {15'b0, e}, r});
      ->smp_ev;
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic pulse(input int p, input logic [EW-1:0] bits);
      @(negedge clk);
      evt[p*EW +: EW] = bits;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic pulse_and_clear(input int p, input logic [EW-1:0] bits,
                                  input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      evt[p*EW +: EW] = bits;
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      evt = '0; we = 1'b0;
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(P0S, 16'h0000, "R1 port0 status");
      rd(P0M, 16'h00FF, "R1 port0 mask");
      rd(P1M, 16'h00FF, "R1 port1 mask");
      rd(HS,  16'h0000, "R1 host status");
      rd(HM,  16'h4003, "R1 host mask");
      rd(HC,  16'h0100, "R1 host control");
      irq_chk(1'b0, "R1 irq low");

      // R2 latching while masked
      pulse(0, 6'b000001);
      rd(P0S, 16'h0001, "R2 removed event latched under full mask");
      rd(HS,  16'h0000, "R7 no pending while masked");

      // R6 operating mask, R5 pending bit
      wr(P0M, 16'h0030);
      rd(P0S, 16'h0081, "R5 pending bit with unmasked event");
      rd(HS,  16'h0001, "R7 host bit0 mirrors port0");

      // R8 host mask open
      wr(HM, 16'h4002);
      rd(HS, 16'h8001, "R8 global summary set");
      irq_chk(1'b0, "R10 interrupt-off holds line low");

      // R10 interrupt-off control
      wr(HC, 16'h0000);
      irq_chk(1'b1, "R10 line high after interrupt-off cleared");
      wr(HC, 16'hFFFF);
      rd(HC, 16'h0100, "R11 host control keeps bit8 only");
      irq_chk(1'b0, "R10 line low with interrupt-off");
      wr(HC, 16'h0000);

      // R6 masked device interrupt; R3 exact clear
      pulse(0, 6'b010000);
      rd(P0S, 16'h0091, "R2 device interrupt latched");
      wr(P0S, 16'h0001);
      rd(P0S, 16'h0010, "R3 only written bit cleared");
      rd(HS,  16'h0000, "R6 masked event does not pend");
      irq_chk(1'b0, "R10 line drops after clear");

      // R5 bits 7 and 6 not writable
      wr(P0S, 16'h00C0);
      rd(P0S, 16'h0010, "R5 write to bits 7/6 ignored");
      wr(P0S, 16'h0010);
      rd(P0S, 16'h0000, "R3 write-back clears");

      // R4 event beats same-cycle clear
      pulse_and_clear(0, 6'b000100, P0S, 16'h0004);
      rd(P0S, 16'h0084, "R4 event wins over clear");
      repeat (5) @(negedge clk);
      irq_chk(1'b1, "R10 level held while cause remains");
      wr(P0S, 16'h0004);
      irq_chk(1'b0, "R10 line low after cause cleared");

      // Port 1: all events, full mask then open
      pulse(1, 6'b111111);
      rd(P1S, 16'h003F, "R2 all six events latched on port1");
      rd(HS,  16'h0000, "R6 full mask silences port1");
      wr(P1M, 16'h0000);
      rd(P1S, 16'h00BF, "R5 port1 pending");
      rd(HS,  16'h0002, "R8 host mask blocks port1 summary");
      wr(HM, 16'h4000);
      rd(HS, 16'h8002, "R8 port1 reaches summary");
      irq_chk(1'b1, "R10 port1 raises line");
      rd(P0S, 16'h0000, "R11 port0 untouched by port1 events");
      wr(P1M, 16'h00FF);
      rd(HS, 16'h0000, "R6 mask 0xFF silences port1");
      irq_chk(1'b0, "R6 line low with port1 silenced");
      wr(P1S, 16'h003F);
      rd(P1S, 16'h0000, "R3 port1 cleared");

      // R9 software interrupt, R7 read-only bits
      wr(HS, 16'hC003);
      rd(HS, 16'h4000, "R9 software bit set, R7 bits 0/1/15 not writable");
      irq_chk(1'b0, "R8 software bit masked");
      wr(HM, 16'h0000);
      rd(HS, 16'hC000, "R9 software bit reaches summary");
      irq_chk(1'b1, "R9 software interrupt raises line");
      wr(HS, 16'h0000);
      irq_chk(1'b0, "R9 software bit cleared");

      // R11 unmapped
      rd(8'h00, 16'h0000, "R11 unmapped reads zero");
      rd(8'h89, 16'h0000, "R11 nonexistent port reads zero");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule